// File: doc/BRIEF.md
# Interrupt Line State and Priority Register Bank

This block keeps the per-line state that an interrupt arbiter works from: for each external interrupt line it stores an enable bit, a pending bit, an active (in-service) bit and a priority level. Software reaches that state through a synchronous register bus. The bus carries a word address, 32-bit write data and four byte strobes. Read data returns one cycle after the read strobe. Enable and pending bits are never written directly. Software writes ones to a separate "set" array or "clear" array, and zeros are ignored. Reading either alias returns the live state.

Hardware also changes the state. A rising edge on a request input marks that line pending. An acknowledge pulse from the arbiter moves a line from pending to active. A completion pulse ends the service and clears the active bit. A write-only trigger register lets software mark a line pending by its number. The enable, pending and priority vectors are driven straight to the arbiter. With the default parameters, 82 lines are implemented within three 32-bit words of bit state.

Top module: `irq_state_bank`

## Requirements
- R1: A write to the set-enable array (word addresses 0x000 to 0x007, byte offsets 0x000 to 0x01F) sets the enable bit of every line whose data bit is 1. A data bit of 0 leaves that enable bit unchanged. Enable bits change only through bus writes.
- R2: A write to the clear-enable array (word addresses 0x020 to 0x027) clears the enable bit of every line whose data bit is 1. It never sets an enable bit.
- R3: The set-pending array (word addresses 0x040 to 0x047) sets pending bits on written ones, and the clear-pending array (word addresses 0x060 to 0x067) clears them on written ones. A read of either set alias or either clear alias returns the current enable or pending state of that word.
- R4: Line n sits in word n/32 at bit n%32 of every bit array. Bits of lines at or beyond NUM_LINES (82 to 95 by default, so word 2 holds only bits 0 to 17) and words 3 to 7 read 0 and ignore writes.
- R5: The active array (word addresses 0x080 to 0x087) is read-only. An acknowledge pulse for line n clears its pending bit and sets its active bit in the same clock edge. A completion pulse for line n clears its active bit.
- R6: Priority storage starts at word address 0x0C0 with one byte per line: line n uses byte lane n%4 of word 0x0C0 + n/4. Only the upper PRIO_BITS (4) bits of each byte are stored. The low nibble and the bytes of unimplemented lines read 0. Only lanes whose byte strobe is set are written.
- R7: A write to the trigger register (word address 0x380) with byte strobe 0 set takes the line number from data bits [7:0] and sets that line's pending bit. A number at or beyond NUM_LINES has no effect.
- R8: A 0-to-1 transition on irqReq[n] sets pending bit n one clock edge later. A request held high does not set the bit again after it has been cleared.
- R9: When a set source (request edge, set-pending write or trigger) and a clear source (clear-pending write or acknowledge) reach the same line in the same cycle, the pending bit ends up set.
- R10: Reset clears all enable, pending, active and priority state and the read data. busRdData shows the addressed word on the cycle after busRdEn is sampled and holds that value until the next read.
- R11: On the bit arrays, bits in a byte lane whose strobe is 0 are treated as written zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 10 | Word address (byte offset divided by 4) |
| busWrData | input | 32 | Write data |
| busByteEn | input | 4 | Byte strobes for the write |
| busRdData | output | 32 | Registered read data |
| irqReq | input | NUM_LINES | Raw request lines, edge sensitive |
| ackValid | input | 1 | Acknowledge pulse from the arbiter |
| ackId | input | ID_W | Line being acknowledged |
| doneValid | input | 1 | Completion pulse |
| doneId | input | ID_W | Line whose service has ended |
| enableVec | output | NUM_LINES | Enable bit per line |
| pendingVec | output | NUM_LINES | Pending bit per line |
| priorityVec | output | NUM_LINES*PRIO_BITS | Stored priority per line, line n at bits n*PRIO_BITS upward |

## Verification
The bench writes to the top word of the bit arrays, where only 18 bits are live. A design that stored the upper bits would read back 0xFFFFFFFF instead of 0x0003FFFF. The bench also writes zeros to a set array and writes ones to a word past the implemented ones. Either write would disturb the enable vector if write-zero were honoured or the decode wrapped around.

Partial byte strobes are applied to both a bit array and a priority word. A design that ignored the strobes, or put the priority nibble in the wrong half of the byte, returns the wrong lanes. A request edge is made to coincide with a clear-pending write, which catches a design where clear wins. A request is held high after its pending bit is cleared, which catches a level-sensitive design that keeps re-pending the line. The acknowledge and completion pulses are checked through the read-only active array, which is also written to. A design that let the bus change the active array would show the written ones on read-back.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;

  localparam int BUS_AW = 10;

  // word-address regions, decoded from busAddr[9:5]
  localparam logic [4:0] REG_SETEN   = 5'd0;
  localparam logic [4:0] REG_CLREN   = 5'd1;
  localparam logic [4:0] REG_SETPEND = 5'd2;
  localparam logic [4:0] REG_CLRPEND = 5'd3;
  localparam logic [4:0] REG_ACTIVE  = 5'd4;
  localparam logic [4:0] REG_PRIO_LO = 5'd6;
  localparam logic [4:0] REG_PRIO_HI = 5'd7;
  localparam logic [BUS_AW-1:0] TRIG_ADDR = 10'h380;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_ENABLE,
    RD_PENDING,
    RD_ACTIVE,
    RD_PRIO
  } rdSel_e;

  typedef struct packed {
    logic       setEn;
    logic       clrEn;
    logic       setPend;
    logic       clrPend;
    logic       prioWr;
    logic       trigWr;
    logic       rdLoad;
    rdSel_e     rdSel;
    logic [5:0] wordIdx;
  } bankStrobe_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
`timescale 1ns/1ps
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_WORDS  = 3,
  parameter int PRIO_WORDS = 21
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_AW-1:0] busAddr,
  output bankStrobe_t       strb
);

  localparam logic [5:0] BIT_LIMIT  = 6'(NUM_WORDS);
  localparam logic [5:0] PRIO_LIMIT = 6'(PRIO_WORDS);

  logic [4:0] region;
  logic       bitWordOk;
  logic       prioWordOk;

  assign region     = busAddr[9:5];
  assign bitWordOk  = {1'b0, busAddr[4:0]} < BIT_LIMIT;
  assign prioWordOk = busAddr[5:0] < PRIO_LIMIT;

  always_comb begin
    strb         = '0;
    strb.rdLoad  = busRdEn;
    strb.rdSel   = RD_ZERO;
    strb.wordIdx = {1'b0, busAddr[4:0]};
    case (region)
      REG_SETEN: if (bitWordOk) begin
        strb.setEn = busWrEn;
        strb.rdSel = RD_ENABLE;
      end
      REG_CLREN: if (bitWordOk) begin
        strb.clrEn = busWrEn;
        strb.rdSel = RD_ENABLE;
      end
      REG_SETPEND: if (bitWordOk) begin
        strb.setPend = busWrEn;
        strb.rdSel   = RD_PENDING;
      end
      REG_CLRPEND: if (bitWordOk) begin
        strb.clrPend = busWrEn;
        strb.rdSel   = RD_PENDING;
      end
      REG_ACTIVE: if (bitWordOk) begin
        strb.rdSel = RD_ACTIVE;
      end
      REG_PRIO_LO, REG_PRIO_HI: begin
        strb.wordIdx = busAddr[5:0];
        if (prioWordOk) begin
          strb.prioWr = busWrEn;
          strb.rdSel  = RD_PRIO;
        end
      end
      default: ;
    endcase
    if (busAddr == TRIG_ADDR) strb.trigWr = busWrEn;
  end

endmodule

// File: rtl/irq_bank_datapath.sv
`timescale 1ns/1ps
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 82,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = 7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bankStrobe_t                    strb,
  input  logic [31:0]                    wrData,
  input  logic [3:0]                     byteEn,
  input  logic [NUM_LINES-1:0]           irqReq,
  input  logic                           ackValid,
  input  logic [ID_W-1:0]                ackId,
  input  logic                           doneValid,
  input  logic [ID_W-1:0]                doneId,
  output logic [NUM_LINES-1:0]           enableQ,
  output logic [NUM_LINES-1:0]           pendingQ,
  output logic [NUM_LINES-1:0]           activeQ,
  output logic [NUM_LINES*PRIO_BITS-1:0] prioFlat,
  output logic [31:0]                    rdData
);

  localparam int BIT_SPAN  = 256;   // eight words per bit array
  localparam int PRIO_SPAN = 2048;  // sixty-four priority words
  localparam int LOW_BITS  = 8 - PRIO_BITS;

  logic [31:0]          wrMask;
  logic [NUM_LINES-1:0] reqPrev;

  assign wrMask = {{8{byteEn[3]}}, {8{byteEn[2]}}, {8{byteEn[1]}}, {8{byteEn[0]}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPrev <= '0;
    else       reqPrev <= irqReq;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int WORD = i / 32;
    localparam int BITP = i % 32;
    localparam int PWRD = i / 4;
    localparam int LANE = i % 4;

    logic wordHit, oneHit;
    logic setEnHit, clrEnHit;
    logic setPendHit, clrPendHit, trigHit, riseHit;
    logic ackHit, doneHit, prioHit;
    logic pendSet, pendClr;
    logic enR, pendR, actR;
    logic [PRIO_BITS-1:0] prioR;

    assign wordHit    = strb.wordIdx == 6'(WORD);
    assign oneHit     = wrData[BITP] & wrMask[BITP] & wordHit;
    assign setEnHit   = strb.setEn & oneHit;
    assign clrEnHit   = strb.clrEn & oneHit;
    assign setPendHit = strb.setPend & oneHit;
    assign clrPendHit = strb.clrPend & oneHit;
    assign trigHit    = strb.trigWr & byteEn[0] & (wrData[7:0] == 8'(i));
    assign riseHit    = irqReq[i] & ~reqPrev[i];
    assign ackHit     = ackValid & (ackId == ID_W'(i));
    assign doneHit    = doneValid & (doneId == ID_W'(i));
    assign prioHit    = strb.prioWr & byteEn[LANE] & (strb.wordIdx == 6'(PWRD));
    assign pendSet    = setPendHit | trigHit | riseHit;
    assign pendClr    = clrPendHit | ackHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enR   <= 1'b0;
        pendR <= 1'b0;
        actR  <= 1'b0;
        prioR <= '0;
      end else begin
        if (setEnHit)      enR <= 1'b1;
        else if (clrEnHit) enR <= 1'b0;
        if (pendSet)       pendR <= 1'b1;
        else if (pendClr)  pendR <= 1'b0;
        if (ackHit)        actR <= 1'b1;
        else if (doneHit)  actR <= 1'b0;
        if (prioHit)       prioR <= wrData[8*LANE+7 -: PRIO_BITS];
      end
    end

    assign enableQ[i]                       = enR;
    assign pendingQ[i]                      = pendR;
    assign activeQ[i]                       = actR;
    assign prioFlat[PRIO_BITS*i +: PRIO_BITS] = prioR;
  end

  // read side: zero-padded views of each array
  logic [BIT_SPAN-1:0]  enPad, pendPad, actPad;
  logic [PRIO_SPAN-1:0] prioPad;
  logic [31:0]          rdNext;

  assign enPad   = BIT_SPAN'(enableQ);
  assign pendPad = BIT_SPAN'(pendingQ);
  assign actPad  = BIT_SPAN'(activeQ);

  always_comb begin
    prioPad = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      prioPad[8*n + LOW_BITS +: PRIO_BITS] = prioFlat[PRIO_BITS*n +: PRIO_BITS];
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_ENABLE:  rdNext = enPad[{strb.wordIdx[2:0], 5'b0} +: 32];
      RD_PENDING: rdNext = pendPad[{strb.wordIdx[2:0], 5'b0} +: 32];
      RD_ACTIVE:  rdNext = actPad[{strb.wordIdx[2:0], 5'b0} +: 32];
      RD_PRIO:    rdNext = prioPad[{strb.wordIdx, 5'b0} +: 32];
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= rdNext;
  end

endmodule

// File: rtl/irq_state_bank.sv
`timescale 1ns/1ps
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 82,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = $clog2(NUM_LINES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWrEn,
  input  logic                           busRdEn,
  input  logic [BUS_AW-1:0]              busAddr,
  input  logic [31:0]                    busWrData,
  input  logic [3:0]                     busByteEn,
  output logic [31:0]                    busRdData,
  input  logic [NUM_LINES-1:0]           irqReq,
  input  logic                           ackValid,
  input  logic [ID_W-1:0]                ackId,
  input  logic                           doneValid,
  input  logic [ID_W-1:0]                doneId,
  output logic [NUM_LINES-1:0]           enableVec,
  output logic [NUM_LINES-1:0]           pendingVec,
  output logic [NUM_LINES*PRIO_BITS-1:0] priorityVec
);

  localparam int NUM_WORDS  = (NUM_LINES + 31) / 32;
  localparam int PRIO_WORDS = (NUM_LINES + 3) / 4;

  bankStrobe_t          strb;
  logic [NUM_LINES-1:0] activeVec;

  irq_bank_ctrl #(
    .NUM_WORDS (NUM_WORDS),
    .PRIO_WORDS(PRIO_WORDS)
  ) u_ctrl (
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .strb   (strb)
  );

  irq_bank_datapath #(
    .NUM_LINES(NUM_LINES),
    .PRIO_BITS(PRIO_BITS),
    .ID_W     (ID_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (busWrData),
    .byteEn   (busByteEn),
    .irqReq   (irqReq),
    .ackValid (ackValid),
    .ackId    (ackId),
    .doneValid(doneValid),
    .doneId   (doneId),
    .enableQ  (enableVec),
    .pendingQ (pendingVec),
    .activeQ  (activeVec),
    .prioFlat (priorityVec),
    .rdData   (busRdData)
  );

endmodule

// File: rtl/irq_state_bank_chk.sv
`timescale 1ns/1ps
module irq_state_bank_chk #(
  parameter int NUM_LINES = 82,
  parameter int ID_W      = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic                 busRdEn,
  input logic [9:0]           busAddr,
  input logic [31:0]          busRdData,
  input logic [NUM_LINES-1:0] irqReq,
  input logic                 ackValid,
  input logic [ID_W-1:0]      ackId,
  input logic                 doneValid,
  input logic [ID_W-1:0]      doneId,
  input logic [NUM_LINES-1:0] enableVec,
  input logic [NUM_LINES-1:0] pendingVec,
  input logic [NUM_LINES-1:0] activeVec
);

  logic [NUM_LINES-1:0] reqSeen;
  logic [NUM_LINES-1:0] reqRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqSeen <= '0;
    else       reqSeen <= irqReq;
  end
  assign reqRise = irqReq & ~reqSeen;

  AST_ENABLE_BUS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(enableVec)); // R1

  AST_CLEAR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[9:5] == 5'd1) |=> ((enableVec & ~$past(enableVec)) == '0)); // R2

  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && int'(ackId) < NUM_LINES) |=> activeVec[$past(ackId)]); // R5

  AST_ACK_UNPENDS: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && int'(ackId) < NUM_LINES && !busWrEn && !reqRise[ackId])
      |=> !pendingVec[$past(ackId)]); // R5

  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && int'(doneId) < NUM_LINES && !(ackValid && ackId == doneId))
      |=> !activeVec[$past(doneId)]); // R5

  AST_EDGE_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendingVec & $past(reqRise)) == $past(reqRise))); // R8

  AST_PRIO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr[9:6] == 4'b0011) |=> ((busRdData & 32'h0F0F0F0F) == 32'h0)); // R6

endmodule

bind irq_state_bank irq_state_bank_chk #(
  .NUM_LINES(NUM_LINES),
  .ID_W     (ID_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .irqReq    (irqReq),
  .ackValid  (ackValid),
  .ackId     (ackId),
  .doneValid (doneValid),
  .doneId    (doneId),
  .enableVec (enableVec),
  .pendingVec(pendingVec),
  .activeVec (activeVec)
);

// File: tb/test_irq_state_bank.sv
`timescale 1ns/1ps
module test_irq_state_bank;

  localparam int N  = 82;
  localparam int PB = 4;
  localparam int IW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0, busRdEn = 1'b0;
  logic [9:0]    busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [3:0]    busByteEn = '0;
  logic [31:0]   busRdData;
  logic [N-1:0]  irqReq = '0;
  logic          ackValid = 1'b0, doneValid = 1'b0;
  logic [IW-1:0] ackId = '0, doneId = '0;
  logic [N-1:0]  enableVec, pendingVec;
  logic [N*PB-1:0] priorityVec;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_state_bank i_irq_state_bank (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busByteEn(busByteEn), .busRdData(busRdData),
    .irqReq(irqReq), .ackValid(ackValid), .ackId(ackId),
    .doneValid(doneValid), .doneId(doneId),
    .enableVec(enableVec), .pendingVec(pendingVec), .priorityVec(priorityVec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busByteEn = be;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0; busByteEn = '0;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic test_reset();
    logic [31:0] r;
    chk("R10 reset enable", {31'b0, |enableVec}, 32'h0);
    chk("R10 reset pending", {31'b0, |pendingVec}, 32'h0);
    chk("R10 reset priority", {31'b0, |priorityVec}, 32'h0);
    chk("R10 reset rdData", busRdData, 32'h0);
    busRead(10'h080, r);
    chk("R10 reset active", r, 32'h0);
  endtask

  task automatic test_set_enable();
    logic [31:0] r;
    busWrite(10'h000, 32'h0000_0005, 4'hF);
    chk("R1 set-enable word0", enableVec[31:0], 32'h5);
    busWrite(10'h000, 32'h0, 4'hF);
    chk("R1 write zero no effect", enableVec[31:0], 32'h5);
    busWrite(10'h001, 32'h0000_0001, 4'hF);
    chk("R1 line32 enabled", enableVec[63:32], 32'h1);
    busRead(10'h020, r);
    chk("R3 clear alias reads enable", r, 32'h5);
  endtask

  task automatic test_clear_enable();
    logic [31:0] r;
    busWrite(10'h020, 32'h0000_0004, 4'hF);
    chk("R2 clear-enable line2", enableVec[31:0], 32'h1);
    busRead(10'h000, r);
    chk("R2 readback set alias", r, 32'h1);
  endtask

  task automatic test_word_tail();
    logic [31:0] r;
    logic [N-1:0] snap;
    busWrite(10'h002, 32'hFFFF_FFFF, 4'hF);
    chk("R4 word2 lines 64..81", {14'b0, enableVec[81:64]}, 32'h0003_FFFF);
    busRead(10'h002, r);
    chk("R4 word2 upper bits read 0", r, 32'h0003_FFFF);
    busRead(10'h022, r);
    chk("R4 word2 via clear alias", r, 32'h0003_FFFF);
    snap = enableVec;
    busWrite(10'h003, 32'hFFFF_FFFF, 4'hF);
    chk("R4 word3 write ignored", {31'b0, enableVec == snap}, 32'h1);
    busRead(10'h003, r);
    chk("R4 word3 reads 0", r, 32'h0);
  endtask

  task automatic test_byte_strobe();
    busWrite(10'h020, 32'hFFFF_FFFF, 4'hF);
    chk("R11 cleared word0", enableVec[31:0], 32'h0);
    busWrite(10'h000, 32'hFFFF_FFFF, 4'b0010);
    chk("R11 only lane1 set", enableVec[31:0], 32'h0000_FF00);
  endtask

  task automatic test_pending_regs();
    logic [31:0] r;
    busWrite(10'h040, 32'h0000_0010, 4'hF);
    chk("R3 set-pending line4", pendingVec[31:0], 32'h10);
    busRead(10'h060, r);
    chk("R3 clear-pending alias read", r, 32'h10);
    busRead(10'h040, r);
    chk("R3 set-pending alias read", r, 32'h10);
    busWrite(10'h060, 32'h0000_0010, 4'hF);
    chk("R3 clear-pending line4", pendingVec[31:0], 32'h0);
  endtask

  task automatic test_edge();
    @(negedge clk); irqReq[5] = 1'b1;
    @(negedge clk);
    chk("R8 rising edge pends line5", {31'b0, pendingVec[5]}, 32'h1);
    busWrite(10'h060, 32'h0000_0020, 4'hF);
    repeat (3) @(negedge clk);
    chk("R8 held level does not re-pend", {31'b0, pendingVec[5]}, 32'h0);
    irqReq[5] = 1'b0;
    @(negedge clk);
    chk("R8 falling edge no pend", {31'b0, pendingVec[5]}, 32'h0);
  endtask

  task automatic test_set_wins();
    @(negedge clk);
    irqReq[9] = 1'b1;
    busWrEn = 1'b1; busAddr = 10'h060; busWrData = 32'h0000_0200; busByteEn = 4'hF;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0; busByteEn = '0;
    chk("R9 edge beats clear-pending", {31'b0, pendingVec[9]}, 32'h1);
    irqReq[9] = 1'b0;
    busWrite(10'h060, 32'h0000_0200, 4'hF);
    chk("R9 clear alone works", {31'b0, pendingVec[9]}, 32'h0);
  endtask

  task automatic test_ack_done();
    logic [31:0] r;
    busWrite(10'h041, 32'h0000_0100, 4'hF);
    chk("R5 line40 pending", {31'b0, pendingVec[40]}, 32'h1);
    @(negedge clk); ackValid = 1'b1; ackId = 7'd40;
    @(negedge clk); ackValid = 1'b0;
    chk("R5 ack clears pending", {31'b0, pendingVec[40]}, 32'h0);
    busRead(10'h081, r);
    chk("R5 ack sets active", r, 32'h0000_0100);
    busWrite(10'h080, 32'hFFFF_FFFF, 4'hF);
    busRead(10'h080, r);
    chk("R5 active is read-only", r, 32'h0);
    @(negedge clk); doneValid = 1'b1; doneId = 7'd40;
    @(negedge clk); doneValid = 1'b0;
    busRead(10'h081, r);
    chk("R5 done clears active", r, 32'h0);
  endtask

  task automatic test_priority();
    logic [31:0] r;
    busWrite(10'h0C3, 32'hFFFF_FFFF, 4'b0010);
    busRead(10'h0C3, r);
    chk("R6 line13 lane1 upper nibble", r, 32'h0000_F000);
    chk("R6 priorityVec line13", {28'b0, priorityVec[13*PB +: PB]}, 32'hF);
    chk("R6 priorityVec line12 untouched", {28'b0, priorityVec[12*PB +: PB]}, 32'h0);
    busWrite(10'h0D4, 32'hFFFF_FFFF, 4'hF);
    busRead(10'h0D4, r);
    chk("R6 R4 last word only lines 80,81", r, 32'h0000_F0F0);
    busRead(10'h0D5, r);
    chk("R6 word beyond lines reads 0", r, 32'h0);
  endtask

  task automatic test_trigger();
    logic [N-1:0] snap;
    busWrite(10'h380, 32'd70, 4'b0001);
    chk("R7 trigger pends line70", {31'b0, pendingVec[70]}, 32'h1);
    snap = pendingVec;
    busWrite(10'h380, 32'd90, 4'b0001);
    chk("R7 out-of-range number ignored", {31'b0, pendingVec == snap}, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_set_enable();
    test_clear_enable();
    test_word_tail();
    test_byte_strobe();
    test_pending_regs();
    test_edge();
    test_set_wins();
    test_ack_done();
    test_priority();
    test_trigger();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule